// File: doc/BRIEF.md
# Elastic Buffer with Skip-Symbol Rate Compensation

This block sits on the receive side of a serial link that carries 10-bit symbols. Received symbols arrive on a recovered write clock and leave on the local read clock through a small dual-clock FIFO. Each pointer is registered as gray code and crosses into the other clock domain through two flip-flops. Each side works out its own view of the fill level from these synchronized pointers.

The gap between the two clock rates is absorbed by changing how many skip symbols pass through. When the write side sees a high fill level, it drops an incoming skip symbol instead of storing it. When the read side sees a low fill level with a skip symbol at the head, it sends that symbol out again and holds its pointer. Three 6-bit thresholds set these levels: an upper level, a lower level and a start level. The start level gates when reading begins.

A bypass input turns compensation off. The FIFO then passes the stream through unchanged and may overrun or run dry, which it reports through sticky flags. An alignment-qualify input restricts compensation to skip symbols that were marked aligned on entry.

Top module: `ebuf_skip_ctl`

## Requirements
- R1: After rst_ni is released, rd_valid_o, wr_ovf_o and rd_udf_o are all 0.
- R2: While no overrun occurs, non-skip symbols leave in the order they were written, with none lost and none duplicated.
- R3: A skip symbol (code 10'h17C) that is eligible for compensation, offered while the write-side fill is at or above max_th_i (recommended 12), is discarded and not stored. With compensation active, a writer faster than the reader therefore never overruns the FIFO.
- R4: When the read-side fill is at or below min_th_i (recommended 2) and the head entry is an eligible skip symbol, that symbol is output again and the read pointer does not advance. With compensation active, a slower writer therefore never causes an underrun.
- R5: After reset or an underrun, rd_valid_o stays 0 until the read-side fill reaches half_th_i (recommended 7). Output then begins on a following read clock.
- R6: With bypass_i = 1, no skip symbol is dropped or repeated, and the output stream equals the input stream.
- R7: A write offered while the FIFO holds 2^AW entries is discarded and sets wr_ovf_o. wr_ovf_o stays set until wr_clr_i is pulsed.
- R8: When reading has started and the read-side fill is 0, rd_valid_o goes low and rd_udf_o is set, and reading waits for the start level again. rd_udf_o stays set until rd_clr_i is pulsed.
- R9: With align_qual_i = 1, only skip symbols written while wr_aligned_i = 1 are eligible for compensation. With align_qual_i = 0, every skip symbol is eligible.
- R10: Each pointer is carried across as gray code, which changes by at most one bit per clock of its source domain, through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered write clock |
| rclk_i | input | 1 | Local read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_valid_i | input | 1 | Symbol present on wr_data_i |
| wr_data_i | input | SYM_W | Received symbol |
| wr_aligned_i | input | 1 | Symbol belongs to an aligned skip set |
| wr_clr_i | input | 1 | Clears wr_ovf_o (write clock) |
| rd_clr_i | input | 1 | Clears rd_udf_o (read clock) |
| bypass_i | input | 1 | Disables all compensation |
| align_qual_i | input | 1 | Compensate only aligned skip symbols |
| max_th_i | input | TH_W | Upper fill level for dropping |
| half_th_i | input | TH_W | Fill level at which reading starts |
| min_th_i | input | TH_W | Lower fill level for repeating |
| rd_valid_o | output | 1 | rd_data_o holds a symbol this cycle |
| rd_data_o | output | SYM_W | Output symbol |
| wr_ovf_o | output | 1 | Sticky overrun flag |
| rd_udf_o | output | 1 | Sticky underrun flag |

## Verification
Compensation only acts when the fill level sits at one of its thresholds and an eligible skip symbol is at that spot. Each fill level is also seen through synchronizer lag. Fixing a fill value directly is therefore impractical. The bench instead runs the read clock at a different period from the write clock and sets the writer's duty and skip density. A faster writer with one skip per four symbols pushes the fill to the upper level, where drops must appear. A half-rate writer that alternates data and skip symbols holds the fill near the lower level, where repeats must appear. The reference queue checks every delivered data symbol against the written order, and the skip counts in and out show which of the two actions took place.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam int unsigned     DEF_SYM_W  = 10;
  localparam logic [9:0]      DEF_SKP    = 10'h17C;
  localparam logic [5:0]      DEF_MAX_TH = 6'd12;
  localparam logic [5:0]      DEF_HALF_TH = 6'd7;
  localparam logic [5:0]      DEF_MIN_TH = 6'd2;

  typedef enum logic [1:0] {WR_IDLE, WR_STORE, WR_DROP, WR_LOST} wr_act_e;
  typedef enum logic {RD_FILL, RD_RUN} rd_st_e;
endpackage

// File: rtl/ebuf_ptr_sync.sv
module ebuf_ptr_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_o[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/ebuf_wr_ctl.sv
module ebuf_wr_ctl
  import ebuf_pkg::*;
#(
  parameter int unsigned       AW      = 4,
  parameter int unsigned       TH_W    = 6,
  parameter int unsigned       SYM_W   = 10,
  parameter logic [SYM_W-1:0]  SKP_SYM = DEF_SKP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SYM_W-1:0] data_i,
  input  logic             aligned_i,
  input  logic             clr_i,
  input  logic             bypass_i,
  input  logic             align_qual_i,
  input  logic [TH_W-1:0]  max_th_i,
  input  logic [AW:0]      rptr_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [AW:0]      wgray_o,
  output logic             ovf_o
);
  localparam int unsigned PW = AW + 1;
  localparam int unsigned CW = (PW > TH_W) ? PW : TH_W;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] wptr_q, wptr_nxt, fill;
  logic [PW-1:0] wgray_q;
  logic          ovf_q;
  logic          eligible, full;
  wr_act_e       act;

  assign fill     = wptr_q - rptr_i;
  assign full     = (fill == DEPTH_P);
  assign eligible = (data_i == SKP_SYM) && (!align_qual_i || aligned_i) && !bypass_i;

  always_comb begin
    if (!valid_i)                                      act = WR_IDLE;
    else if (eligible && CW'(fill) >= CW'(max_th_i))   act = WR_DROP;
    else if (full)                                     act = WR_LOST;
    else                                               act = WR_STORE;
  end

  assign we_o     = (act == WR_STORE);
  assign wptr_nxt = wptr_q + PW'(we_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      if (clr_i)            ovf_q <= 1'b0;
      if (act == WR_LOST)   ovf_q <= 1'b1;
    end
  end

  assign waddr_o = wptr_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign ovf_o   = ovf_q;

  // R10
  wgray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  // R7
  wr_fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= DEPTH_P);
  // R7
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(fill) == DEPTH_P);
  // R6
  bypass_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && valid_i && fill < DEPTH_P) |=> wptr_q == $past(wptr_q) + 1'b1);
endmodule

// File: rtl/ebuf_rd_ctl.sv
module ebuf_rd_ctl
  import ebuf_pkg::*;
#(
  parameter int unsigned       AW      = 4,
  parameter int unsigned       TH_W    = 6,
  parameter int unsigned       SYM_W   = 10,
  parameter logic [SYM_W-1:0]  SKP_SYM = DEF_SKP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW:0]      wptr_i,
  input  logic [SYM_W-1:0] head_i,
  input  logic             head_aligned_i,
  input  logic             clr_i,
  input  logic             bypass_i,
  input  logic             align_qual_i,
  input  logic [TH_W-1:0]  half_th_i,
  input  logic [TH_W-1:0]  min_th_i,
  output logic [AW-1:0]    raddr_o,
  output logic [AW:0]      rgray_o,
  output logic             valid_o,
  output logic [SYM_W-1:0] data_o,
  output logic             udf_o
);
  localparam int unsigned PW = AW + 1;
  localparam int unsigned CW = (PW > TH_W) ? PW : TH_W;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0]    rptr_q, rptr_nxt, fill;
  logic [PW-1:0]    rgray_q;
  logic [SYM_W-1:0] data_q;
  logic             valid_q, udf_q, hold, advance;
  rd_st_e           st_q;

  assign fill = wptr_i - rptr_q;
  assign hold = !bypass_i && (head_i == SKP_SYM) && (!align_qual_i || head_aligned_i)
                && (CW'(fill) <= CW'(min_th_i));
  assign advance  = (st_q == RD_RUN) && (fill != '0) && !hold;
  assign rptr_nxt = rptr_q + PW'(advance);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RD_FILL;
      rptr_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      udf_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      rptr_q  <= rptr_nxt;
      rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      if (clr_i) udf_q <= 1'b0;
      if (st_q == RD_FILL) begin
        if (CW'(fill) >= CW'(half_th_i)) st_q <= RD_RUN;
      end else if (fill == '0) begin
        st_q  <= RD_FILL;
        udf_q <= 1'b1;
      end else begin
        valid_q <= 1'b1;
        data_q  <= head_i;
      end
    end
  end

  assign raddr_o = rptr_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign udf_o   = udf_q;

  // R8
  rd_fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= DEPTH_P);
  // R8
  rd_valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(fill) != '0);
  // R4
  repeat_is_skp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $stable(rptr_q)) |-> data_o == SKP_SYM);
endmodule

// File: rtl/ebuf_skip_ctl.sv
module ebuf_skip_ctl
  import ebuf_pkg::*;
#(
  parameter int unsigned       AW      = 4,
  parameter int unsigned       TH_W    = 6,
  parameter int unsigned       SYM_W   = DEF_SYM_W,
  parameter logic [SYM_W-1:0]  SKP_SYM = DEF_SKP
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [SYM_W-1:0] wr_data_i,
  input  logic             wr_aligned_i,
  input  logic             wr_clr_i,
  input  logic             rd_clr_i,
  input  logic             bypass_i,
  input  logic             align_qual_i,
  input  logic [TH_W-1:0]  max_th_i,
  input  logic [TH_W-1:0]  half_th_i,
  input  logic [TH_W-1:0]  min_th_i,
  output logic             rd_valid_o,
  output logic [SYM_W-1:0] rd_data_o,
  output logic             wr_ovf_o,
  output logic             rd_udf_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  logic [SYM_W:0]  mem [DEPTH];
  logic            we;
  logic [AW-1:0]   waddr, raddr;
  logic [PW-1:0]   wgray, rgray, wptr_rd, rptr_wr;
  logic [SYM_W:0]  head;

  always_ff @(posedge wclk_i) begin
    if (we) mem[waddr] <= {wr_aligned_i, wr_data_i};
  end

  assign head = mem[raddr];

  ebuf_ptr_sync #(.W(PW)) u_rptr_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rptr_wr));

  ebuf_ptr_sync #(.W(PW)) u_wptr_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wptr_rd));

  ebuf_wr_ctl #(.AW(AW), .TH_W(TH_W), .SYM_W(SYM_W), .SKP_SYM(SKP_SYM)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .valid_i(wr_valid_i), .data_i(wr_data_i),
    .aligned_i(wr_aligned_i), .clr_i(wr_clr_i), .bypass_i(bypass_i),
    .align_qual_i(align_qual_i), .max_th_i(max_th_i), .rptr_i(rptr_wr),
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray), .ovf_o(wr_ovf_o));

  ebuf_rd_ctl #(.AW(AW), .TH_W(TH_W), .SYM_W(SYM_W), .SKP_SYM(SKP_SYM)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .wptr_i(wptr_rd), .head_i(head[SYM_W-1:0]),
    .head_aligned_i(head[SYM_W]), .clr_i(rd_clr_i), .bypass_i(bypass_i),
    .align_qual_i(align_qual_i), .half_th_i(half_th_i), .min_th_i(min_th_i),
    .raddr_o(raddr), .rgray_o(rgray), .valid_o(rd_valid_o), .data_o(rd_data_o),
    .udf_o(rd_udf_o));
endmodule

// File: tb/tb_ebuf_skip_ctl.sv
module tb_ebuf_skip_ctl;
  import ebuf_pkg::*;

  localparam int WCLK_PERIOD = 10;
  localparam logic [9:0] SKP = DEF_SKP;

  logic wclk = 1'b0, rclk = 1'b0;
  int   rhalf = WCLK_PERIOD / 2;
  logic rst_ni = 1'b0;
  logic wr_valid = 1'b0, wr_aligned = 1'b0, wr_clr = 1'b0, rd_clr = 1'b0;
  logic bypass = 1'b0, align_qual = 1'b0;
  logic [9:0] wr_data = '0;
  logic [5:0] max_th = DEF_MAX_TH, half_th = DEF_HALF_TH, min_th = DEF_MIN_TH;
  logic rd_valid_o, wr_ovf_o, rd_udf_o;
  logic [9:0] rd_data_o;

  always #(WCLK_PERIOD / 2) wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  ebuf_skip_ctl dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_aligned_i(wr_aligned), .wr_clr_i(wr_clr),
    .rd_clr_i(rd_clr), .bypass_i(bypass), .align_qual_i(align_qual),
    .max_th_i(max_th), .half_th_i(half_th), .min_th_i(min_th),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .wr_ovf_o(wr_ovf_o),
    .rd_udf_o(rd_udf_o));

  int checks = 0, fails = 0;
  int out_cnt = 0, skp_in = 0, skp_out = 0, dcnt = 0;
  bit mon_on = 0, mon_exact = 0, done = 0;
  logic [9:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: queue of expected symbols, compared on every read clock
  always @(negedge rclk) begin
    if (mon_on && rd_valid_o) begin
      logic [9:0] e;
      out_cnt++;
      if (mon_exact) begin
        if (q.size() == 0) chk(0, "R6 output with empty model", int'(rd_data_o), -1);
        else begin e = q.pop_front(); chk(rd_data_o == e, "R6 exact stream", int'(rd_data_o), int'(e)); end
      end else if (rd_data_o == SKP) begin
        skp_out++;
      end else begin
        if (q.size() == 0) chk(0, "R2 extra data symbol", int'(rd_data_o), -1);
        else begin e = q.pop_front(); chk(rd_data_o == e, "R2 data order", int'(rd_data_o), int'(e)); end
      end
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0; wr_valid = 1'b0; wr_clr = 1'b0; rd_clr = 1'b0;
    repeat (3) @(negedge wclk);
    q.delete(); out_cnt = 0; skp_in = 0; skp_out = 0;
    rst_ni = 1'b1;
    @(negedge rclk);
    chk(rd_valid_o == 1'b0, "R1 rd_valid after reset", int'(rd_valid_o), 0);
    chk(wr_ovf_o == 1'b0, "R1 ovf after reset", int'(wr_ovf_o), 0);
    chk(rd_udf_o == 1'b0, "R1 udf after reset", int'(rd_udf_o), 0);
  endtask

  task automatic send(input int n, input int skp_every, input int gap);
    for (int i = 0; i < n; i++) begin
      logic [9:0] s;
      if (skp_every != 0 && (i % skp_every) == skp_every - 1) s = SKP;
      else begin s = 10'(dcnt % 256); dcnt++; end
      @(negedge wclk);
      wr_valid = 1'b1; wr_data = s;
      if (s == SKP) skp_in++;
      if (mon_exact || s != SKP) q.push_back(s);
      repeat (gap) begin @(negedge wclk); wr_valid = 1'b0; end
    end
    @(negedge wclk);
    wr_valid = 1'b0;
  endtask

  task automatic rwait(input int n);
    repeat (n) @(negedge rclk);
  endtask

  initial begin
    // R5/R8: start level, underrun, clear, restart
    rhalf = 5; do_reset(); mon_on = 1;
    send(6, 0, 0); rwait(30);
    chk(out_cnt == 0, "R5 no output below start level", out_cnt, 0);
    send(1, 0, 0); rwait(30);
    chk(out_cnt == 7, "R5 output after start level", out_cnt, 7);
    chk(rd_udf_o == 1'b1, "R8 underrun flag set", int'(rd_udf_o), 1);
    @(negedge rclk) rd_clr = 1'b1;
    @(negedge rclk) rd_clr = 1'b0;
    @(negedge rclk);
    chk(rd_udf_o == 1'b0, "R8 underrun flag cleared", int'(rd_udf_o), 0);
    send(3, 0, 0); rwait(30);
    chk(out_cnt == 7, "R5 waits again after underrun", out_cnt, 7);
    send(4, 0, 0); rwait(30);
    chk(out_cnt == 14, "R5 restart at start level", out_cnt, 14);
    chk(q.size() == 0, "R2 all data delivered", q.size(), 0);

    // R3/R9: fast writer, every skip eligible (qualify off, not aligned)
    rhalf = 6; align_qual = 0; wr_aligned = 0; do_reset(); mon_on = 1;
    send(300, 4, 0);
    chk(skp_out < skp_in, "R3 skip symbols dropped", skp_out, skp_in);
    chk(wr_ovf_o == 1'b0, "R3 no overrun with compensation", int'(wr_ovf_o), 0);
    mon_on = 0;

    // R4: slow writer, alternating data and skip
    rhalf = 5; do_reset(); mon_on = 1;
    send(200, 2, 1);
    chk(skp_out > skp_in, "R4 skip symbols repeated", skp_out, skp_in);
    chk(rd_udf_o == 1'b0, "R4 no underrun with compensation", int'(rd_udf_o), 0);
    mon_on = 0;

    // R6: bypass passes stream unchanged, then runs dry
    rhalf = 5; bypass = 1; do_reset(); mon_exact = 1; mon_on = 1;
    send(10, 4, 0); rwait(40);
    chk(out_cnt == 10, "R6 symbol count unchanged", out_cnt, 10);
    chk(rd_udf_o == 1'b1, "R8 underrun under bypass", int'(rd_udf_o), 1);
    mon_on = 0; mon_exact = 0;

    // R7: bypass overrun and clear
    rhalf = 15; do_reset();
    send(40, 4, 0); rwait(2);
    chk(wr_ovf_o == 1'b1, "R7 overrun flag set", int'(wr_ovf_o), 1);
    @(negedge wclk) wr_clr = 1'b1;
    @(negedge wclk) wr_clr = 1'b0;
    @(negedge wclk);
    chk(wr_ovf_o == 1'b0, "R7 overrun flag cleared", int'(wr_ovf_o), 0);
    bypass = 0;

    // R9: qualify on, skips not aligned -> no compensation -> overrun
    rhalf = 6; align_qual = 1; wr_aligned = 0; do_reset();
    send(300, 4, 0);
    chk(wr_ovf_o == 1'b1, "R9 unaligned skips not compensated", int'(wr_ovf_o), 1);

    // R9: qualify on, skips aligned -> compensated
    wr_aligned = 1; do_reset(); mon_on = 1;
    send(300, 4, 0);
    chk(wr_ovf_o == 1'b0, "R9 aligned skips compensated", int'(wr_ovf_o), 0);
    chk(skp_out < skp_in, "R9 aligned skips dropped", skp_out, skp_in);
    mon_on = 0; align_qual = 0; wr_aligned = 0;

    // R5: programmable start level
    rhalf = 5; half_th = 6'd3; do_reset(); mon_on = 1;
    send(3, 0, 0); rwait(20);
    chk(out_cnt == 3, "R5 lower start level", out_cnt, 3);
    mon_on = 0; half_th = DEF_HALF_TH;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(WCLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule